// File: doc/BRIEF.md
# Dual-Width Binary/Decimal Accumulator Adder

This block adds an operand and an incoming carry to an accumulator value and writes the sum back as the new accumulator. The accumulator is both an addend and the destination. The width select picks 8-bit or 16-bit operation. The decimal select picks plain binary addition or packed-BCD addition, in which each 4-bit nibble holds one decimal digit. With every result the block also produces four status flags: negative (N), overflow (V), zero (Z) and carry (C).

A processor datapath drives the operands and the mode selects, then pulses `start` for one cycle. On that clock edge the block latches the result and the flags. One cycle after `start`, `done` is high for a single cycle. The outputs then hold their values until the next `start`. Decimal correction is done inside the same cycle, so both modes have the same latency.

Top module: `acc_adder`

## Requirements
- R1: In binary mode the result is acc_in + operand + carry_in at the selected width, so a set carry_in always adds one.
- R2: C is set when the unsigned sum exceeds 0xFF in 8-bit mode (wide=0), or 0xFFFF in 16-bit mode (wide=1), and is cleared otherwise.
- R3: Z is set exactly when the result is zero at the selected width (bits 7:0 when wide=0, bits 15:0 when wide=1).
- R4: N equals the most significant bit of the result at the selected width: bit 7 when wide=0, bit 15 when wide=1.
- R5: V is set when both addends have the same sign bit at the selected width and the sign bit of their binary sum (including carry_in) differs. In decimal mode V comes from this binary sum, taken before decimal correction.
- R6: With decimal=1 the addends are packed BCD. Digits are processed from least to most significant. Any digit whose sum is greater than 9 gets 6 added, and a carry goes into the next digit. There are 2 digits when wide=0 and 4 digits when wide=1. The carry out of the last digit becomes C.
- R7: When wide=0, acc_out[15:8] equals acc_in[15:8] sampled at start, whatever the operand and carry.
- R8: acc_out and the flags take their new values on the edge where start is high, and done is high in the following cycle only.
- R9: While start is low, acc_out, n, v, z and c keep their values and done stays low.
- R10: After the synchronous active-high reset, acc_out is 0, all flags are 0 and done is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Latch a new sum on this edge |
| acc_in | input | 16 | Current accumulator value (addend) |
| operand | input | 16 | Second addend |
| carry_in | input | 1 | Incoming carry |
| wide | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| decimal | input | 1 | 1 = packed-BCD addition, 0 = binary addition |
| acc_out | output | 16 | New accumulator value |
| n | output | 1 | Negative flag |
| v | output | 1 | Signed overflow flag |
| z | output | 1 | Zero flag |
| c | output | 1 | Carry-out flag |
| done | output | 1 | One-cycle pulse the cycle after start |

## Verification
The assertions check on every cycle:
- the start/done timing (R8);
- the holding of outputs between starts (R9);
- the untouched upper byte in 8-bit mode (R7);
- the way N and Z follow the registered result at the width that was latched (R3, R4).

The arithmetic itself can only be shown by the bench's scenarios. These are:
- binary and decimal sums checked against a reference model that works on decimal integers;
- the carry and overflow boundaries at 0xFF/0xFFFF and 99/9999;
- the effect of carry_in;
- decimal-mode V taken from the uncorrected sum.

// File: rtl/acc_add_pkg.sv
package acc_add_pkg;
    localparam int DATA_W   = 16;
    localparam int NARROW_W = DATA_W / 2;
    localparam int DIGIT_W  = 4;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              carry;
        logic              ovf;
    } sum_t;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flags_t;

    // signed overflow: equal input signs, different result sign
    function automatic logic sign_ovf(input logic sa, input logic sb, input logic sr);
        return (sa == sb) && (sr != sa);
    endfunction
endpackage

// File: rtl/acc_bin_core.sv
module acc_bin_core
    import acc_add_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         wide,
    output sum_t         res
);
    localparam int H = W / 2;

    logic [W:0] full_sum;
    logic [H:0] half_sum;

    always_comb begin
        full_sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        half_sum = {1'b0, a[H-1:0]} + {1'b0, b[H-1:0]} + {{H{1'b0}}, cin};
        if (wide) begin
            res.value = full_sum[W-1:0];
            res.carry = full_sum[W];
            res.ovf   = sign_ovf(a[W-1], b[W-1], full_sum[W-1]);
        end else begin
            res.value = {a[W-1:H], half_sum[H-1:0]};
            res.carry = half_sum[H];
            res.ovf   = sign_ovf(a[H-1], b[H-1], half_sum[H-1]);
        end
    end
endmodule

// File: rtl/acc_bcd_core.sv
module acc_bcd_core
    import acc_add_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int DW = DIGIT_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         wide,
    output logic [W-1:0] value,
    output logic         carry
);
    localparam int ND  = W / DW;
    localparam int NDN = ND / 2;
    localparam int H   = W / 2;
    localparam logic [DW:0]   DEC_MAX = (DW+1)'(9);
    localparam logic [DW-1:0] DEC_ADJ = DW'((1 << DW) - 10);

    logic [ND:0]   dcy;
    logic [W-1:0]  digits;

    assign dcy[0] = cin;

    for (genvar i = 0; i < ND; i++) begin : g_digit
        logic [DW:0] raw;
        logic        over;
        always_comb begin
            raw  = {1'b0, a[i*DW +: DW]} + {1'b0, b[i*DW +: DW]} + {{DW{1'b0}}, dcy[i]};
            over = raw > DEC_MAX;
            digits[i*DW +: DW] = over ? (raw[DW-1:0] + DEC_ADJ) : raw[DW-1:0];
        end
        assign dcy[i+1] = over;
    end

    always_comb begin
        if (wide) begin
            value = digits;
            carry = dcy[ND];
        end else begin
            value = {a[W-1:H], digits[H-1:0]};
            carry = dcy[NDN];
        end
    end
endmodule

// File: rtl/acc_adder.sv
module acc_adder
    import acc_add_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] operand,
    input  logic              carry_in,
    input  logic              wide,
    input  logic              decimal,
    output logic [DATA_W-1:0] acc_out,
    output logic              n,
    output logic              v,
    output logic              z,
    output logic              c,
    output logic              done
);
    sum_t              bin_res;
    logic [DATA_W-1:0] bcd_value;
    logic              bcd_carry;
    logic [DATA_W-1:0] next_value;
    flags_t            next_flags;
    flags_t            flags_q;

    acc_bin_core #(.W(DATA_W)) u_bin (
        .a(acc_in), .b(operand), .cin(carry_in), .wide(wide), .res(bin_res)
    );

    acc_bcd_core #(.W(DATA_W), .DW(DIGIT_W)) u_bcd (
        .a(acc_in), .b(operand), .cin(carry_in), .wide(wide),
        .value(bcd_value), .carry(bcd_carry)
    );

    always_comb begin
        next_value   = decimal ? bcd_value : bin_res.value;
        next_flags.c = decimal ? bcd_carry : bin_res.carry;
        next_flags.v = bin_res.ovf;
        next_flags.n = wide ? next_value[DATA_W-1] : next_value[NARROW_W-1];
        next_flags.z = wide ? (next_value == '0) : (next_value[NARROW_W-1:0] == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_out <= '0;
            flags_q <= '0;
            done    <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                acc_out <= next_value;
                flags_q <= next_flags;
            end
        end
    end

    assign n = flags_q.n;
    assign v = flags_q.v;
    assign z = flags_q.z;
    assign c = flags_q.c;
endmodule

// File: rtl/acc_adder_chk.sv
module acc_adder_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        wide,
    input logic [7:0]  acc_in_hi,
    input logic [15:0] acc_out,
    input logic        n,
    input logic        v,
    input logic        z,
    input logic        c,
    input logic        done
);
    // R8
    done_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    // R9
    idle_no_done_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);

    // R9
    hold_outputs_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(acc_out) && $stable({n, v, z, c})));

    // R7
    upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !wide) |=> (acc_out[15:8] == $past(acc_in_hi)));

    // R3
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (start && wide) |=> (z == (acc_out == 16'h0000)));

    // R3
    zero_narrow_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !wide) |=> (z == (acc_out[7:0] == 8'h00)));

    // R4
    neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (n == ($past(wide) ? acc_out[15] : acc_out[7])));
endmodule

bind acc_adder acc_adder_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .wide(wide),
    .acc_in_hi(acc_in[15:8]), .acc_out(acc_out),
    .n(n), .v(v), .z(z), .c(c), .done(done)
);

// File: tb/sim_acc_adder.sv
module sim_acc_adder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [15:0] acc_in;
    logic [15:0] operand;
    logic        carry_in;
    logic        wide;
    logic        decimal;
    logic [15:0] acc_out;
    logic        n, v, z, c, done;

    int tests  = 0;
    int failed = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_adder u0 (
        .clk(clk), .rst(rst), .start(start), .acc_in(acc_in), .operand(operand),
        .carry_in(carry_in), .wide(wide), .decimal(decimal),
        .acc_out(acc_out), .n(n), .v(v), .z(z), .c(c), .done(done)
    );

    function automatic int bcd_to_int(input int val, input int nd);
        int r = 0;
        int m = 1;
        for (int i = 0; i < nd; i++) begin
            r += ((val >> (4*i)) & 15) * m;
            m *= 10;
        end
        return r;
    endfunction

    function automatic int int_to_bcd(input int val, input int nd);
        int r = 0;
        int t = val;
        for (int i = 0; i < nd; i++) begin
            r |= (t % 10) << (4*i);
            t /= 10;
        end
        return r;
    endfunction

    // returns {acc[15:0], n, v, z, c}
    function automatic logic [19:0] model(input logic [15:0] a, input logic [15:0] b,
                                          input logic ci, input logic w, input logic d);
        int bits = w ? 16 : 8;
        int mask = w ? 32'hFFFF : 32'hFF;
        int nd   = w ? 4 : 2;
        int la   = int'(a) & mask;
        int lb   = int'(b) & mask;
        int bs   = la + lb + int'(ci);
        int r;
        logic cc, vv, sa, sb, sr, nn, zz;
        logic [15:0] outv;
        if (d) begin
            int lim = w ? 10000 : 100;
            int s   = bcd_to_int(la, nd) + bcd_to_int(lb, nd) + int'(ci);
            cc = (s >= lim);
            r  = int_to_bcd(s % lim, nd);
        end else begin
            cc = (bs > mask);
            r  = bs & mask;
        end
        sa = logic'((la >> (bits-1)) & 1);
        sb = logic'((lb >> (bits-1)) & 1);
        sr = logic'((bs >> (bits-1)) & 1);
        vv = (sa == sb) && (sr != sa);
        nn = logic'((r >> (bits-1)) & 1);
        zz = (r == 0);
        outv = w ? 16'(r) : {a[15:8], 8'(r)};
        return {outv, nn, vv, zz, cc};
    endfunction

    task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %05h expected %05h", req, act, exp);
        end
    endtask

    task automatic run_op(input string req, input logic [15:0] a, input logic [15:0] b,
                          input logic ci, input logic w, input logic d);
        @(negedge clk);
        acc_in = a; operand = b; carry_in = ci; wide = w; decimal = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({req, " done"}, {19'd0, done}, 20'd1);
        check(req, {acc_out, n, v, z, c}, model(a, b, ci, w, d));
    endtask

    function automatic logic [15:0] rand_bcd();
        logic [15:0] r = '0;
        for (int i = 0; i < 4; i++) r[4*i +: 4] = 4'($urandom_range(9, 0));
        return r;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        failed++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        logic [19:0] held;
        void'($urandom(32'd1234));
        rst = 1'b1; start = 1'b0; acc_in = 16'h5A5A; operand = 16'hA5A5;
        carry_in = 1'b1; wide = 1'b1; decimal = 1'b0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10", {acc_out, n, v, z, c}, 20'd0);
        check("R10 done", {19'd0, done}, 20'd0);
        rst = 1'b0;

        run_op("R1", 16'h0010, 16'h0020, 1'b1, 1'b0, 1'b0);
        run_op("R1", 16'h1234, 16'h1111, 1'b0, 1'b1, 1'b0);
        run_op("R2", 16'h00FF, 16'h0001, 1'b0, 1'b0, 1'b0);
        run_op("R2", 16'hFFFF, 16'h0000, 1'b1, 1'b1, 1'b0);
        run_op("R2", 16'h00FF, 16'h0100, 1'b0, 1'b1, 1'b0);
        run_op("R3", 16'h7700, 16'h0000, 1'b0, 1'b0, 1'b0);
        run_op("R4", 16'h007F, 16'h0001, 1'b0, 1'b0, 1'b0);
        run_op("R4", 16'h7FFF, 16'h0001, 1'b0, 1'b1, 1'b0);
        run_op("R5", 16'h0080, 16'h0080, 1'b0, 1'b0, 1'b0);
        run_op("R5", 16'h8000, 16'hFFFF, 1'b1, 1'b1, 1'b0);
        run_op("R5", 16'h0079, 16'h0001, 1'b0, 1'b0, 1'b1);
        run_op("R6", 16'h0099, 16'h0001, 1'b0, 1'b0, 1'b1);
        run_op("R6", 16'h0058, 16'h0046, 1'b1, 1'b0, 1'b1);
        run_op("R6", 16'h9999, 16'h0000, 1'b1, 1'b1, 1'b1);
        run_op("R6", 16'h0909, 16'h0101, 1'b0, 1'b1, 1'b1);
        run_op("R7", 16'hAB12, 16'h3405, 1'b0, 1'b0, 1'b0);
        run_op("R7", 16'hCD95, 16'hFF07, 1'b1, 1'b0, 1'b1);

        // R8 done is a single-cycle pulse
        @(negedge clk);
        check("R8 pulse", {19'd0, done}, 20'd0);

        // R9 outputs hold while start is low
        held = {acc_out, n, v, z, c};
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            acc_in = 16'($urandom); operand = 16'($urandom);
            carry_in = ~carry_in; wide = ~wide; decimal = ~decimal;
        end
        @(negedge clk);
        check("R9 hold", {acc_out, n, v, z, c}, held);
        check("R9 done", {19'd0, done}, 20'd0);

        for (int i = 0; i < 300; i++)
            run_op("R1 rand", 16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), 1'b0);
        for (int i = 0; i < 300; i++)
            run_op("R6 rand", rand_bcd(), rand_bcd(), 1'($urandom), 1'($urandom), 1'b1);

        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule